// File: doc/BRIEF.md
# Latched serial-in parallel-out register

The block turns a serial bit stream into a parallel word in two separate steps. Each rising edge of the shift clock moves the serial input into the first stage of a shift chain, and every other stage takes the bit of the stage before it. A rising edge of the store clock copies the whole chain into a storage register, and only that register reaches the parallel pins. The shift chain can therefore be refilled while the outputs hold a steady word.

An active-low clear empties the shift chain at once, without a clock, and holds it empty while it stays low. The storage register is not touched by the clear. An active-low output enable either drives the stored word onto the parallel pins or releases every pin to high impedance. The last shift stage also leaves the block as a cascade output. This output is not gated by the enable and does not pass through the storage register, so any number of copies can be chained to form a wider register. The width is a parameter with a default of 8.

Top module: `latched_sipo`

## Requirements
- R1: After the clear has been low and a store edge follows, every parallel output reads 0 and the cascade output reads 0.
- R2: On each rising shift-clock edge with the clear high, stage 0 takes the serial input and stage i takes the old value of stage i-1. Parallel bit 0 is stage 0, and bit W-1 is the last stage.
- R3: A low clear zeroes the shift chain immediately, with no clock edge. Shift edges that arrive while the clear is low have no effect, and this shows at the cascade output.
- R4: A rising store-clock edge copies the shift chain into the storage register. The parallel outputs change only on store edges, never on shift edges.
- R5: While the output enable is high, every parallel output is high impedance. While it is low, the parallel outputs drive the stored word.
- R6: The cascade output always equals the last shift stage, whatever the state of the output enable or of the storage register.
- R7: When both clocks rise on the same edge, the storage register takes the shift chain as it was before that edge, so the stored word lags by one pulse.
- R8: The clear leaves the storage register unchanged. The stored word stays on the outputs until the next store edge.
- R9: With two copies chained through the cascade output, 2*W shift edges followed by one store edge place the first W bits shifted in on the far copy and the last W bits on the near copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock, rising-edge active |
| shift_clr_n | input | 1 | Asynchronous clear of the shift chain, active low |
| serial_in | input | 1 | Serial data into stage 0 |
| store_clk | input | 1 | Store clock, rising-edge active |
| out_en_n | input | 1 | Parallel output enable, active low |
| par_out | output | W | Stored word, high impedance when disabled |
| chain_out | output | 1 | Last shift stage, for cascading |

## Verification
The bench shifts known bytes and confirms that the parallel pins stay put across shift edges. A design that fed the shift chain straight to the pins would fail this check. It clears between two store edges and also pulses the shift clock during the clear. Each of the following faults would show up as a mismatch:
- a clear that also wiped the storage register,
- a clear that needed a clock edge,
- a shift edge that got past the clear.

The bench disables the outputs while shifting continues, to catch a cascade output gated by the enable. Tied-clock pulses expose a storage register that samples the chain after the edge instead of before it. A two-device chain exposes reversed bit order or a cascade tap taken from the wrong stage.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
    localparam int SIPO_DEF_W = 8;

    typedef enum logic {
        LINE_DRIVE = 1'b0,
        LINE_FLOAT = 1'b1
    } line_mode_e;
endpackage

// File: rtl/sipo_shift_stage.sv
module sipo_shift_stage #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         clr_ni,
    input  logic         bit_i,
    output logic [W-1:0] stages_o
);
    typedef struct packed {
        logic [W-1:0] stages;
    } shift_state_t;

    shift_state_t state_d, state_q;

    generate
        if (W == 1) begin : g_single
            always_comb begin
                state_d        = state_q;
                state_d.stages = bit_i;
            end
        end else begin : g_multi
            always_comb begin
                state_d        = state_q;
                state_d.stages = {state_q.stages[W-2:0], bit_i};
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge clr_ni) begin
        if (!clr_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign stages_o = state_q.stages;
endmodule

// File: rtl/sipo_hold_stage.sv
module sipo_hold_stage #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic [W-1:0] load_i,
    output logic [W-1:0] held_o
);
    typedef struct packed {
        logic [W-1:0] word;
    } hold_state_t;

    hold_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.word = load_i;
    end

    // No reset: the stored word survives the shift-chain clear.
    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign held_o = state_q.word;
endmodule

// File: rtl/latched_sipo.sv
module latched_sipo
    import sipo_pkg::*;
#(
    parameter int W = SIPO_DEF_W
) (
    input  logic         shift_clk,
    input  logic         shift_clr_n,
    input  logic         serial_in,
    input  logic         store_clk,
    input  logic         out_en_n,
    output logic [W-1:0] par_out,
    output logic         chain_out
);
    localparam int LAST = W - 1;

    logic [W-1:0] shift_vec;
    logic [W-1:0] hold_vec;
    line_mode_e   line_mode;

    sipo_shift_stage #(.W(W)) u_shift (
        .clk_i    (shift_clk),
        .clr_ni   (shift_clr_n),
        .bit_i    (serial_in),
        .stages_o (shift_vec)
    );

    sipo_hold_stage #(.W(W)) u_hold (
        .clk_i  (store_clk),
        .load_i (shift_vec),
        .held_o (hold_vec)
    );

    assign line_mode = out_en_n ? LINE_FLOAT : LINE_DRIVE;
    assign par_out   = (line_mode == LINE_FLOAT) ? {W{1'bz}} : hold_vec;
    assign chain_out = shift_vec[LAST];
endmodule

// File: rtl/latched_sipo_chk.sv
module latched_sipo_chk #(
    parameter int W = 8
) (
    input logic         shift_clk,
    input logic         shift_clr_n,
    input logic         serial_in,
    input logic         store_clk,
    input logic         chain_out,
    input logic [W-1:0] shift_vec,
    input logic [W-1:0] hold_vec
);
    logic sh_run;
    logic st_armed;

    // Set once a shift edge has passed with no clear since.
    always_ff @(posedge shift_clk or negedge shift_clr_n) begin
        if (!shift_clr_n) sh_run <= 1'b0;
        else              sh_run <= 1'b1;
    end

    always_ff @(posedge store_clk or negedge shift_clr_n) begin
        if (!shift_clr_n) st_armed <= 1'b0;
        else              st_armed <= 1'b1;
    end

    // R3: a low clear empties the chain regardless of shift edges
    a_r3_clear_empties: assert property (@(posedge shift_clk)
        !shift_clr_n |-> shift_vec == '0);

    // R2: stage 0 takes the serial bit of the previous edge
    a_r2_entry_bit: assert property (@(posedge shift_clk) disable iff (!shift_clr_n)
        sh_run |-> shift_vec[0] == $past(serial_in));

    generate
        if (W > 1) begin : g_wide
            // R2: each stage takes its neighbour's old value
            a_r2_stage_move: assert property (@(posedge shift_clk) disable iff (!shift_clr_n)
                sh_run |-> shift_vec[W-1:1] == $past(shift_vec[W-2:0]));

            // R6: cascade output follows the stage below the last
            a_r6_cascade_tap: assert property (@(posedge shift_clk) disable iff (!shift_clr_n)
                sh_run |-> chain_out == $past(shift_vec[W-2]));
        end
    endgenerate

    // R4: a store edge copies the chain as it stood at that edge
    a_r4_store_copy: assert property (@(posedge store_clk) disable iff (!shift_clr_n)
        st_armed |-> hold_vec == $past(shift_vec));
endmodule

bind latched_sipo latched_sipo_chk #(.W(W)) u_chk (
    .shift_clk   (shift_clk),
    .shift_clr_n (shift_clr_n),
    .serial_in   (serial_in),
    .store_clk   (store_clk),
    .chain_out   (chain_out),
    .shift_vec   (shift_vec),
    .hold_vec    (hold_vec)
);

// File: tb/test_latched_sipo.sv
`timescale 1ns/1ps
module test_latched_sipo;
    localparam int W = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic shift_clk   = 1'b0;
    logic store_clk   = 1'b0;
    logic shift_clr_n = 1'b1;
    logic serial_in   = 1'b0;
    logic out_en_n    = 1'b0;

    wire [W-1:0] par_lo, par_hi;
    wire         chain_lo, chain_hi;

    latched_sipo #(.W(W)) i_latched_sipo (
        .shift_clk   (shift_clk),
        .shift_clr_n (shift_clr_n),
        .serial_in   (serial_in),
        .store_clk   (store_clk),
        .out_en_n    (out_en_n),
        .par_out     (par_lo),
        .chain_out   (chain_lo)
    );

    latched_sipo #(.W(W)) i_latched_sipo_hi (
        .shift_clk   (shift_clk),
        .shift_clr_n (shift_clr_n),
        .serial_in   (chain_lo),
        .store_clk   (store_clk),
        .out_en_n    (out_en_n),
        .par_out     (par_hi),
        .chain_out   (chain_hi)
    );

    // Reference model built from the requirements
    logic [W-1:0] m_lo = '0, m_hi = '0, s_lo = '0, s_hi = '0;

    typedef struct {
        logic [W-1:0] lo;
        logic [W-1:0] hi;
        logic         c_lo;
        logic         c_hi;
        string        req;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;

    task automatic model_shift(input logic b);
        if (shift_clr_n) begin
            m_hi = {m_hi[W-2:0], m_lo[W-1]};
            m_lo = {m_lo[W-2:0], b};
        end
    endtask

    task automatic do_shift(input logic b);
        @(negedge clk) serial_in = b;
        @(negedge clk) shift_clk = 1'b1;
        model_shift(b);
        @(negedge clk) shift_clk = 1'b0;
    endtask

    task automatic do_store();
        @(negedge clk) store_clk = 1'b1;
        s_lo = m_lo;
        s_hi = m_hi;
        @(negedge clk) store_clk = 1'b0;
    endtask

    // R7: both clocks rise together
    task automatic do_both(input logic b);
        @(negedge clk) serial_in = b;
        @(negedge clk) begin
            shift_clk = 1'b1;
            store_clk = 1'b1;
        end
        s_lo = m_lo;
        s_hi = m_hi;
        model_shift(b);
        @(negedge clk) begin
            shift_clk = 1'b0;
            store_clk = 1'b0;
        end
    endtask

    task automatic expect_now(input string req);
        exp_t it;
        #1;
        it.lo   = out_en_n ? {W{1'bz}} : s_lo;
        it.hi   = out_en_n ? {W{1'bz}} : s_hi;
        it.c_lo = m_lo[W-1];
        it.c_hi = m_hi[W-1];
        it.req  = req;
        exp_q.push_back(it);
        wait (exp_q.size() == 0);
    endtask

    // Monitor: pops expected items and compares with the pins
    initial begin
        forever begin
            exp_t it;
            wait (exp_q.size() != 0);
            it = exp_q[0];
            n_vec++;
            if (par_lo !== it.lo || par_hi !== it.hi ||
                chain_lo !== it.c_lo || chain_hi !== it.c_hi) begin
                n_bad++;
                $display("FAIL %s: act lo=%h hi=%h c=%b%b exp lo=%h hi=%h c=%b%b",
                         it.req, par_lo, par_hi, chain_hi, chain_lo,
                         it.lo, it.hi, it.c_hi, it.c_lo);
            end
            void'(exp_q.pop_front());
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: act running exp finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] pat;
        // R1: clear, then a store edge gives an all-zero word
        #2 shift_clr_n = 1'b0;
        m_lo = '0;
        m_hi = '0;
        do_store();
        @(negedge clk) shift_clr_n = 1'b1;
        expect_now("R1");

        // R2 / R4: shift 0xA5 MSB first; outputs hold until the store
        pat = 8'hA5;
        for (int i = 7; i >= 0; i--) begin
            do_shift(pat[i]);
            expect_now("R2");
        end
        do_store();
        expect_now("R4");

        // R5: outputs released; R6: cascade keeps moving
        @(negedge clk) out_en_n = 1'b1;
        expect_now("R5");
        do_shift(1'b0);
        expect_now("R6");
        do_shift(1'b1);
        expect_now("R6");
        @(negedge clk) out_en_n = 1'b0;
        expect_now("R5");

        // R3 / R8: async clear between store edges, shift pulse inside it
        @(negedge clk) shift_clr_n = 1'b0;
        m_lo = '0;
        m_hi = '0;
        expect_now("R3");
        do_shift(1'b1);
        expect_now("R3");
        @(negedge clk) shift_clr_n = 1'b1;
        expect_now("R8");
        do_store();
        expect_now("R8");

        // R7: tied clocks, storage lags one pulse
        pat = 8'h3C;
        for (int i = 7; i >= 0; i--) begin
            do_both(pat[i]);
            expect_now("R7");
        end

        // R9: two chained copies, 16 shifts then one store
        pat = 8'h96;
        for (int i = 7; i >= 0; i--) do_shift(pat[i]);
        pat = 8'h5A;
        for (int i = 7; i >= 0; i--) do_shift(pat[i]);
        do_store();
        expect_now("R9");
        if (s_hi !== 8'h96 || s_lo !== 8'h5A) begin
            n_bad++;
            $display("FAIL R9 model: act %h%h exp 965a", s_hi, s_lo);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule